// File: doc/BRIEF.md
# SPI Serial Byte-Memory Write Controller

This block is an SPI mode-0 slave that fronts a 512-byte register array. A master selects the device, shifts in a one-byte command, and for memory commands follows it with an address byte. The ninth address bit does not get its own byte. It is carried inside the command byte, so one command byte and one address byte together give the full 9-bit start location.

A store is armed by a separate arm command sent in an earlier chip-select frame. After the address, every complete byte the master clocks in is written to the array, and the internal pointer advances after each byte, wrapping from the top location back to zero. A fetch command returns array contents on the serial output from the same kind of 9-bit start address, so the array can be inspected through the pins.

All SPI pins are sampled in the block's own clock domain and then edge-detected. SCLK must therefore run well below the system clock.

Top module: `spi_wmem`

## Requirements
- R1: Opcode 0x06 sets the write-enable latch. A store command is acted on only when the latch was set before that store command's frame began.
- R2: Opcode 0x04 clears the write-enable latch, so a later store command is ignored.
- R3: Store opcode is binary 0000_A_010 and fetch opcode is 0000_A_011. Bit 3 (A) is address bit 8, and the next byte supplies address bits 7..0.
- R4: Bytes after the address are received MSB first on the rising SCLK edge and written to the start address and then to consecutive addresses.
- R5: The address pointer wraps from 0x1FF to 0x000 during both stores and fetches.
- R6: A byte is written only once all 8 of its bits have arrived. A partial byte at chip-select deassertion is dropped.
- R7: The latch clears at the end of a store frame that wrote at least one byte. A store frame that ends before any data byte completes leaves the latch set.
- R8: Deasserting chip select returns the bit counter and the command decoder to idle, so the next frame begins with an opcode.
- R9: A store command issued while the latch is clear leaves the array unchanged.
- R10: A fetch returns bytes MSB first on miso_o. Each bit changes after a falling SCLK edge, starting at the addressed byte and incrementing.
- R11: After reset the whole array reads 0x00, and miso_o is low whenever chip select is deasserted.
- R12: Any other opcode makes the rest of the frame ignored, and the latch is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock, mode 0 |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |

## Verification
The bench targets four corner cases:
- **Wrap at the top of the array.** A store or fetch that crosses 0x1FF must continue at 0x000. A design that carries into a tenth bit or saturates would overwrite or return the wrong location.
- **Bit 8 taken from the command byte.** Stores are steered to 0x100 and above. A decoder that ignored bit 3 would alias them onto the low half.
- **Latch life-cycle.** The bench checks an arm followed by a store with no data bytes, which must stay armed. It checks an arm followed by a disarm, and a second store after a successful one, both of which must be dropped. It also checks that an unknown opcode does not consume the arm. A latch cleared at the wrong moment shows up as a missing or unexpected write.
- **Truncated frames.** The bench cuts frames short mid-byte and mid-opcode. A design that committed partial bytes, or kept a stale bit count into the next frame, would corrupt the following location or misread the next command.

// File: rtl/spi_wmem_pkg.sv
package spi_wmem_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int A8_POS = 3;

  localparam logic [DATA_W-1:0] OP_ARM    = 8'h06;
  localparam logic [DATA_W-1:0] OP_DISARM = 8'h04;
  localparam logic [2:0]        OP_STORE  = 3'b010;
  localparam logic [2:0]        OP_FETCH  = 3'b011;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } ctrl_state_e;
endpackage

// File: rtl/spi_wmem_sync.sv
module spi_wmem_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stage[g-1].q;
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/spi_wmem_array.sv
module spi_wmem_array
  import spi_wmem_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R4: a write strobe lands its byte at the strobed location
  assert_write_lands_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/spi_wmem_ctrl.sv
module spi_wmem_ctrl
  import spi_wmem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              cs_rise_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  ctrl_state_e       state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] sh_q, out_q, wr_data_q;
  logic [ADDR_W-1:0] addr_q, wr_addr_q;
  logic              a_hi_q, store_q, wel_q, wrote_q, we_q;

  logic [DATA_W-1:0] byte_w;
  logic              byte_done, is_store, is_fetch;

  assign byte_w    = {sh_q[DATA_W-2:0], mosi_i};
  assign byte_done = cs_act_i && sclk_rise_i && (bit_cnt_q == LAST_BIT);
  assign is_store  = (byte_w[7:4] == 4'h0) && (byte_w[2:0] == OP_STORE);
  assign is_fetch  = (byte_w[7:4] == 4'h0) && (byte_w[2:0] == OP_FETCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CMD;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      out_q     <= '0;
      addr_q    <= '0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      a_hi_q    <= 1'b0;
      store_q   <= 1'b0;
      wel_q     <= 1'b0;
      wrote_q   <= 1'b0;
      we_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (cs_rise_i && wrote_q) wel_q <= 1'b0;
      if (!cs_act_i) begin
        state_q   <= ST_CMD;
        bit_cnt_q <= '0;
        wrote_q   <= 1'b0;
        out_q     <= '0;
      end else begin
        if (sclk_rise_i) begin
          sh_q      <= byte_w;
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        if (byte_done) begin
          unique case (state_q)
            ST_CMD: begin
              if (byte_w == OP_ARM) begin
                wel_q   <= 1'b1;
                state_q <= ST_SKIP;
              end else if (byte_w == OP_DISARM) begin
                wel_q   <= 1'b0;
                state_q <= ST_SKIP;
              end else if ((is_store && wel_q) || is_fetch) begin
                a_hi_q  <= byte_w[A8_POS];
                store_q <= is_store;
                state_q <= ST_ADDR;
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              addr_q  <= {a_hi_q, byte_w};
              state_q <= store_q ? ST_WDATA : ST_RDATA;
            end
            ST_WDATA: begin
              we_q      <= 1'b1;
              wr_addr_q <= addr_q;
              wr_data_q <= byte_w;
              addr_q    <= addr_q + 1'b1;
              wrote_q   <= 1'b1;
            end
            default: ;
          endcase
        end
        if (sclk_fall_i && state_q == ST_RDATA) begin
          if (bit_cnt_q == '0) begin
            out_q  <= rd_data_i;
            addr_q <= addr_q + 1'b1;
          end else begin
            out_q <= out_q << 1;
          end
        end
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign we_o      = we_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign miso_o    = out_q[DATA_W-1];

  assert_we_needs_wel_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> wel_q);
  assert_disarm_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && state_q == ST_CMD && byte_w == OP_DISARM) |=> !wel_q);
  assert_ptr_wraps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && state_q == ST_WDATA) |=> addr_q == ADDR_W'(wr_addr_q + 1'b1));
  assert_whole_byte_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(bit_cnt_q) == LAST_BIT);
  assert_wel_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && wrote_q) |=> !wel_q);
  assert_deselect_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> (state_q == ST_CMD && bit_cnt_q == '0));
  assert_miso_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !miso_o);
endmodule

// File: rtl/spi_wmem.sv
module spi_wmem
  import spi_wmem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic miso_o
);
  logic [2:0] pins_s;
  logic       cs_s, sclk_s, mosi_s;
  logic       cs_prev_q, sclk_prev_q;
  logic       we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] wdata, rdata;

  spi_wmem_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, mosi_i}),
    .q_o   (pins_s)
  );

  assign {cs_s, sclk_s, mosi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_s;
      sclk_prev_q <= sclk_s;
    end
  end

  spi_wmem_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (!cs_s),
    .cs_rise_i  (cs_s && !cs_prev_q),
    .sclk_rise_i(sclk_s && !sclk_prev_q),
    .sclk_fall_i(!sclk_s && sclk_prev_q),
    .mosi_i     (mosi_s),
    .rd_data_i  (rdata),
    .rd_addr_o  (raddr),
    .we_o       (we),
    .wr_addr_o  (waddr),
    .wr_data_o  (wdata),
    .miso_o     (miso_o)
  );

  spi_wmem_array u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );
endmodule

// File: tb/spi_wmem_test.sv
module spi_wmem_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF       = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic miso;
  int   n_checks = 0, n_fail = 0;
  logic [7:0] exp_mem [512];
  bit   wel_m = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_wmem uut (
    .clk_i (clk), .rst_ni(rst_n), .cs_ni(cs_n),
    .sclk_i(sclk), .mosi_i(mosi), .miso_o(miso)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      idle(HALF);
      rx[i] = miso;
      sclk = 1'b1;
      idle(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    idle(HALF);
  endtask

  task automatic cs_hi();
    idle(HALF);
    cs_n = 1'b1;
    idle(2 * HALF);
  endtask

  task automatic one_cmd(input logic [7:0] op);
    logic [7:0] rx;
    cs_lo();
    xfer(op, 8, rx);
    cs_hi();
    if (op == 8'h06) wel_m = 1'b1;
    if (op == 8'h04) wel_m = 1'b0;
  endtask

  function automatic logic [7:0] store_op(input logic [8:0] a);
    return {4'h0, a[8], 3'b010};
  endfunction

  function automatic logic [7:0] fetch_op(input logic [8:0] a);
    return {4'h0, a[8], 3'b011};
  endfunction

  // store n whole bytes plus optional trailing partial bits
  task automatic store(input logic [8:0] a, input int n, input int tail_bits);
    logic [7:0] rx, d;
    logic [8:0] p;
    cs_lo();
    xfer(store_op(a), 8, rx);
    xfer(a[7:0], 8, rx);
    p = a;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      xfer(d, 8, rx);
      if (wel_m) exp_mem[p] = d;
      p = p + 9'd1;
    end
    if (tail_bits > 0) xfer(8'($urandom), tail_bits, rx);
    cs_hi();
    if (wel_m && n > 0) wel_m = 1'b0;
  endtask

  task automatic fetch_check(input logic [8:0] a, input int n, input string tag);
    logic [7:0] rx;
    logic [8:0] p;
    cs_lo();
    xfer(fetch_op(a), 8, rx);
    xfer(a[7:0], 8, rx);
    p = a;
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, rx);
      check(rx === exp_mem[p], tag, {7'd0, p}, {8'd0, exp_mem[p]});
      if (rx !== exp_mem[p]) $display("  at addr %h got %h", p, rx);
      p = p + 9'd1;
    end
    cs_hi();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [8:0] a;
    int n;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R11: reset state
    check(miso === 1'b0, "R11 miso idle", {15'd0, miso}, 16'd0);
    fetch_check(9'h000, 4, "R11 reset contents");
    fetch_check(9'h1FE, 2, "R11 reset contents top");

    // R9: store without arm ignored
    store(9'h010, 3, 0);
    fetch_check(9'h010, 3, "R9 store while disarmed");

    // R1 R3 R4: armed store into upper half, bit 8 from opcode
    one_cmd(8'h06);
    store(9'h120, 4, 0);
    fetch_check(9'h120, 4, "R4 consecutive bytes");
    fetch_check(9'h020, 4, "R3 bit8 not aliased");

    // R7: latch consumed, second store dropped
    store(9'h040, 2, 0);
    fetch_check(9'h040, 2, "R7 latch cleared after write");

    // R5: wrap on store and fetch
    one_cmd(8'h06);
    store(9'h1FE, 4, 0);
    fetch_check(9'h1FD, 5, "R5 wrap");

    // R7: store frame with no data keeps latch
    one_cmd(8'h06);
    store(9'h060, 0, 0);
    store(9'h060, 2, 0);
    fetch_check(9'h060, 2, "R7 empty frame keeps latch");

    // R2: disarm
    one_cmd(8'h06);
    one_cmd(8'h04);
    store(9'h070, 2, 0);
    fetch_check(9'h070, 2, "R2 disarm");

    // R12: unknown opcode frame ignored, latch kept
    one_cmd(8'h06);
    begin
      logic [7:0] rx;
      cs_lo();
      xfer(8'h9F, 8, rx);
      xfer(8'h80, 8, rx);
      xfer(8'h5A, 8, rx);
      cs_hi();
    end
    fetch_check(9'h080, 2, "R12 unknown opcode no write");
    store(9'h088, 1, 0);
    fetch_check(9'h088, 1, "R12 latch kept");

    // R6: partial trailing byte discarded
    one_cmd(8'h06);
    store(9'h0A0, 1, 5);
    fetch_check(9'h0A0, 2, "R6 partial byte");

    // R8: aborted mid-opcode frame, next frame decodes cleanly
    begin
      logic [7:0] rx;
      cs_lo();
      xfer(8'h06, 3, rx);
      cs_hi();
    end
    fetch_check(9'h120, 2, "R8 restart after abort");
    one_cmd(8'h06);
    store(9'h0B0, 1, 0);
    fetch_check(9'h0B0, 1, "R8 opcode after abort");

    // random mix
    for (int k = 0; k < 14; k++) begin
      a = 9'($urandom);
      n = 1 + int'($urandom % 5);
      if ($urandom % 4 != 0) one_cmd(8'h06);
      store(a, n, int'($urandom % 3));
      fetch_check(a, n, "R4 random store");
    end

    // R10: full sweep fetch, wrapping through the top
    fetch_check(9'h1F0, 512, "R10 sweep");
    check(miso === 1'b0, "R11 miso after frame", {15'd0, miso}, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule